// File: doc/BRIEF.md
# Pixel Format Expander

This block turns one stored layer pixel into a 32-bit ARGB value (alpha, red, green and blue, 8 bits each) for a downstream blender. A 3-bit code picks one of eight storage layouts: direct colour with or without its own alpha, narrow 16-bit colour, or an index into a 256-entry colour table, optionally paired with an alpha field. Narrow fields are widened to 8 bits by repeating their upper bits.

Index formats are resolved through an on-block table of 24-bit RGB entries that is filled through a simple write port. A single bit of the layer control word turns the table on. When it is clear, an index is shown as a grey level. Every format has the same one-cycle latency, so the output stream keeps the spacing of the input stream.

Top module: `pixfmt_expand`

## Requirements
- R1: Code 0 passes `pix[31:0]` through as A,R,G,B (A in bits 31:24, R 23:16, G 15:8, B 7:0). Code 1 takes R,G,B from `pix[23:0]` in the same positions and ignores `pix[31:24]`.
- R2: Code 2 reads R from `pix[15:11]`, G from `pix[10:5]` and B from `pix[4:0]`. R and B widen as `{c, c[4:2]}` and G widens as `{g, g[5:4]}`. Bits 31:16 are ignored.
- R3: Code 3 reads A from `pix[15]`, R from `pix[14:10]`, G from `pix[9:5]` and B from `pix[4:0]`. A widens to 0x00 or 0xFF, and the colour fields widen as `{c, c[4:2]}`.
- R4: Code 4 reads A, R, G and B from the nibbles at bits 15:12, 11:8, 7:4 and 3:0. Each nibble c widens to `{c, c}`.
- R5: Formats with no alpha of their own (codes 1, 2 and 5) always output alpha 0xFF.
- R6: With table enable (bit 4 of `layer_ctrl`) set, code 5 outputs `{0xFF, table[pix[7:0]]}`.
- R7: With table enable set, code 6 outputs alpha `{pix[7:4], pix[7:4]}` and colour `table[{4'h0, pix[3:0]}]`. Code 7 outputs alpha `pix[15:8]` and colour `table[pix[7:0]]`.
- R8: With table enable clear, the index formats output the index as grey, that is R = G = B. The grey value is `pix[7:0]` for codes 5 and 7 and `{pix[3:0], pix[3:0]}` for code 6. Alpha is the same as in R6 and R7. All other `layer_ctrl` bits have no effect.
- R9: `out_valid` equals `in_valid` delayed by exactly one clock for every format. The pixel captured at a rising edge appears on `out_argb` right after that edge.
- R10: After reset `out_valid` is 0 and `out_argb` is 0. While `in_valid` is low, `out_argb` holds its last value, even if the table is written.
- R11: A table write (`tbl_we`, `tbl_idx`, `tbl_rgb` with R in 23:16, G 15:8, B 7:0) is seen by pixels captured in later cycles. A pixel captured in the same cycle that reads the same entry gets the old content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| layer_ctrl | input | CTRL_W | Layer control word; bit TBL_EN_BIT enables the table |
| in_valid | input | 1 | Input pixel strobe |
| in_fmt | input | 3 | Storage format code 0..7 |
| in_pix | input | PIX_W | Raw pixel, LSB aligned |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 8 | Table entry to write |
| tbl_rgb | input | 24 | RGB value to write |
| out_valid | output | 1 | Output pixel strobe |
| out_argb | output | 32 | Expanded ARGB pixel |

## Verification
Every result is due one clock after the rising edge that captured its input: the expanded pixel, the valid strobe and a table lookup alike. Table writes take effect from the following edge. The bench drives inputs on the falling edge. It checks the outputs on the next falling edge against a value it computed when it drove that pixel, using a table model that was read before the same cycle's write was applied. During idle cycles the bench carries the previous expected value forward, so the hold behaviour is checked on every gap, including gaps that contain table writes.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;

   localparam int CHAN_W  = 8;
   localparam int ARGB_W  = 4 * CHAN_W;
   localparam int RGB_W   = 3 * CHAN_W;
   localparam int INDEX_W = 8;

   typedef enum logic [2:0] {
      FMT_ARGB32   = 3'd0,
      FMT_RGB24    = 3'd1,
      FMT_RGB16    = 3'd2,
      FMT_ARGB16A1 = 3'd3,
      FMT_ARGB16A4 = 3'd4,
      FMT_IDX8     = 3'd5,
      FMT_AIDX8    = 3'd6,
      FMT_AIDX16   = 3'd7
   } pixfmt_e;

   // Set for layouts that carry their own alpha field.
   function automatic logic fmt_has_alpha(pixfmt_e f);
      case (f)
         FMT_RGB24, FMT_RGB16, FMT_IDX8: return 1'b0;
         default:                        return 1'b1;
      endcase
   endfunction

   function automatic logic fmt_is_index(pixfmt_e f);
      return (f == FMT_IDX8) || (f == FMT_AIDX8) || (f == FMT_AIDX16);
   endfunction

endpackage

// File: rtl/pixfmt_widen.sv
// Widens an IN_W-bit channel to OUT_W bits by repeating it from the top down.
module pixfmt_widen #(
   parameter int IN_W  = 5,
   parameter int OUT_W = 8
) (
   input  logic [IN_W-1:0]  d,
   output logic [OUT_W-1:0] q
);

   if (IN_W < 1 || IN_W > OUT_W) begin : g_bad_width
      $error("pixfmt_widen: IN_W must lie in 1..OUT_W");
   end

   if (IN_W == OUT_W) begin : g_pass
      assign q = d;
   end else begin : g_repl
      for (genvar i = 0; i < OUT_W; i++) begin : g_bit
         assign q[OUT_W-1-i] = d[IN_W-1-(i % IN_W)];
      end
   end

endmodule

// File: rtl/pixfmt_unpack.sv
// Combinational field extraction for all eight layouts.
module pixfmt_unpack
   import pixfmt_pkg::*;
(
   input  pixfmt_e              fmt,
   input  logic [ARGB_W-1:0]    pix,
   input  logic                 tbl_on,
   output logic                 use_tbl,
   output logic [INDEX_W-1:0]   idx,
   output logic [CHAN_W-1:0]    alpha,
   output logic [ARGB_W-1:0]    argb
);

   logic [CHAN_W-1:0] r565, g565, b565;
   logic [CHAN_W-1:0] a1555, r1555, g1555, b1555;
   logic [CHAN_W-1:0] nib_w [4];
   logic [CHAN_W-1:0] al44_a, al44_i;

   pixfmt_widen #(.IN_W(5), .OUT_W(CHAN_W)) u_r565 (.d(pix[15:11]), .q(r565));
   pixfmt_widen #(.IN_W(6), .OUT_W(CHAN_W)) u_g565 (.d(pix[10:5]),  .q(g565));
   pixfmt_widen #(.IN_W(5), .OUT_W(CHAN_W)) u_b565 (.d(pix[4:0]),   .q(b565));

   pixfmt_widen #(.IN_W(1), .OUT_W(CHAN_W)) u_a1555 (.d(pix[15]),    .q(a1555));
   pixfmt_widen #(.IN_W(5), .OUT_W(CHAN_W)) u_r1555 (.d(pix[14:10]), .q(r1555));
   pixfmt_widen #(.IN_W(5), .OUT_W(CHAN_W)) u_g1555 (.d(pix[9:5]),   .q(g1555));
   pixfmt_widen #(.IN_W(5), .OUT_W(CHAN_W)) u_b1555 (.d(pix[4:0]),   .q(b1555));

   for (genvar k = 0; k < 4; k++) begin : g_nib
      pixfmt_widen #(.IN_W(4), .OUT_W(CHAN_W)) u_nib (.d(pix[4*k+3 -: 4]), .q(nib_w[k]));
   end

   pixfmt_widen #(.IN_W(4), .OUT_W(CHAN_W)) u_al44_a (.d(pix[7:4]), .q(al44_a));
   pixfmt_widen #(.IN_W(4), .OUT_W(CHAN_W)) u_al44_i (.d(pix[3:0]), .q(al44_i));

   logic [CHAN_W-1:0] grey;

   always_comb begin
      idx   = pix[INDEX_W-1:0];
      alpha = 8'hFF;
      grey  = pix[7:0];
      argb  = pix;
      case (fmt)
         FMT_ARGB32:   argb = pix;
         FMT_RGB24:    argb = {8'hFF, pix[23:0]};
         FMT_RGB16:    argb = {8'hFF, r565, g565, b565};
         FMT_ARGB16A1: argb = {a1555, r1555, g1555, b1555};
         FMT_ARGB16A4: argb = {nib_w[3], nib_w[2], nib_w[1], nib_w[0]};
         FMT_IDX8: begin
            alpha = 8'hFF;
            grey  = pix[7:0];
            argb  = {alpha, grey, grey, grey};
         end
         FMT_AIDX8: begin
            idx   = {4'h0, pix[3:0]};
            alpha = al44_a;
            grey  = al44_i;
            argb  = {alpha, grey, grey, grey};
         end
         FMT_AIDX16: begin
            alpha = pix[15:8];
            grey  = pix[7:0];
            argb  = {alpha, grey, grey, grey};
         end
         default: argb = pix;
      endcase
   end

   assign use_tbl = fmt_is_index(fmt) && tbl_on;

endmodule

// File: rtl/pixfmt_clut.sv
// Colour table: one write port, one registered read port, read-before-write.
module pixfmt_clut #(
   parameter int IDX_W = 8,
   parameter int DAT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [DAT_W-1:0] wdata,
   input  logic             re,
   input  logic [IDX_W-1:0] raddr,
   output logic [DAT_W-1:0] rdata
);

   localparam int DEPTH = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_depth
      $error("pixfmt_clut: IDX_W out of range");
   end

   logic [DAT_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end

endmodule

// File: rtl/pixfmt_expand.sv
module pixfmt_expand
   import pixfmt_pkg::*;
#(
   parameter int PIX_W      = 32,
   parameter int CTRL_W     = 8,
   parameter int TBL_EN_BIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] layer_ctrl,
   input  logic              in_valid,
   input  logic [2:0]        in_fmt,
   input  logic [PIX_W-1:0]  in_pix,
   input  logic              tbl_we,
   input  logic [7:0]        tbl_idx,
   input  logic [23:0]       tbl_rgb,
   output logic              out_valid,
   output logic [31:0]       out_argb
);

   if (PIX_W < ARGB_W) begin : g_bad_pix
      $error("pixfmt_expand: PIX_W must hold a 32-bit pixel");
   end
   if (TBL_EN_BIT >= CTRL_W) begin : g_bad_ctrl
      $error("pixfmt_expand: TBL_EN_BIT outside control word");
   end

   pixfmt_e              fmt;
   logic                 tbl_on;
   logic                 u_use_tbl;
   logic [INDEX_W-1:0]   u_idx;
   logic [CHAN_W-1:0]    u_alpha;
   logic [ARGB_W-1:0]    u_argb;
   logic                 ctrl_unused;

   assign fmt         = pixfmt_e'(in_fmt);
   assign tbl_on      = layer_ctrl[TBL_EN_BIT];
   assign ctrl_unused = ^{layer_ctrl, in_pix};

   pixfmt_unpack u_unpack (
      .fmt     (fmt),
      .pix     (in_pix[ARGB_W-1:0]),
      .tbl_on  (tbl_on),
      .use_tbl (u_use_tbl),
      .idx     (u_idx),
      .alpha   (u_alpha),
      .argb    (u_argb)
   );

   logic [RGB_W-1:0] tbl_q;

   pixfmt_clut #(.IDX_W(INDEX_W), .DAT_W(RGB_W)) u_clut (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tbl_we),
      .waddr (tbl_idx),
      .wdata (tbl_rgb),
      .re    (in_valid),
      .raddr (u_idx),
      .rdata (tbl_q)
   );

   // Direct path staged alongside the table read.
   logic              s_valid;
   logic              s_use_tbl;
   logic [CHAN_W-1:0] s_alpha;
   logic [ARGB_W-1:0] s_argb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_valid   <= 1'b0;
         s_use_tbl <= 1'b0;
         s_alpha   <= '0;
         s_argb    <= '0;
      end else begin
         s_valid <= in_valid;
         if (in_valid) begin
            s_use_tbl <= u_use_tbl;
            s_alpha   <= u_alpha;
            s_argb    <= u_argb;
         end
      end
   end

   assign out_valid = s_valid;
   assign out_argb  = s_use_tbl ? {s_alpha, tbl_q} : s_argb;

   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                            // R9
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);                                          // R9
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_argb));                                   // R10
   AST_OPAQUE_ALPHA: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !fmt_has_alpha(fmt)) |=> (out_argb[31:24] == 8'hFF));  // R5
   AST_GREY_L8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fmt == FMT_IDX8 && !tbl_on)
         |=> (out_argb == {8'hFF, {3{$past(in_pix[7:0])}}}));             // R8
   AST_AL88_ALPHA: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fmt == FMT_AIDX16)
         |=> (out_argb[31:24] == $past(in_pix[15:8])));                   // R7

endmodule

// File: tb/pixfmt_expand_test.sv
module pixfmt_expand_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  layer_ctrl = '0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_fmt = '0;
   logic [31:0] in_pix = '0;
   logic        tbl_we = 1'b0;
   logic [7:0]  tbl_idx = '0;
   logic [23:0] tbl_rgb = '0;
   logic        out_valid;
   logic [31:0] out_argb;

   always #10 clk = ~clk;   // 50 MHz

   pixfmt_expand uut (
      .clk(clk), .rst_n(rst_n), .layer_ctrl(layer_ctrl), .in_valid(in_valid),
      .in_fmt(in_fmt), .in_pix(in_pix), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
      .tbl_rgb(tbl_rgb), .out_valid(out_valid), .out_argb(out_argb)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [23:0] mdl [256];
   logic        exp_v    = 1'b0;
   logic [31:0] exp_argb = '0;
   logic [2:0]  exp_fmt  = '0;
   string       exp_tag  = "R10";

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, expv, $time);
      end
   endtask

   function automatic logic [7:0] w5(input logic [4:0] c);  return {c, c[4:2]}; endfunction
   function automatic logic [7:0] w6(input logic [5:0] c);  return {c, c[5:4]}; endfunction
   function automatic logic [7:0] w4(input logic [3:0] c);  return {c, c};      endfunction

   function automatic logic [31:0] model(input logic [2:0] f, input logic [31:0] p, input bit en);
      logic [7:0] a, g;
      case (f)
         3'd0: return p;
         3'd1: return {8'hFF, p[23:0]};
         3'd2: return {8'hFF, w5(p[15:11]), w6(p[10:5]), w5(p[4:0])};
         3'd3: return {p[15] ? 8'hFF : 8'h00, w5(p[14:10]), w5(p[9:5]), w5(p[4:0])};
         3'd4: return {w4(p[15:12]), w4(p[11:8]), w4(p[7:4]), w4(p[3:0])};
         3'd5: begin a = 8'hFF;        g = p[7:0];      return en ? {a, mdl[p[7:0]]} : {a, g, g, g}; end
         3'd6: begin a = w4(p[7:4]);   g = w4(p[3:0]);  return en ? {a, mdl[{4'h0, p[3:0]}]} : {a, g, g, g}; end
         default: begin a = p[15:8];   g = p[7:0];      return en ? {a, mdl[p[7:0]]} : {a, g, g, g}; end
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] f, input bit en);
      case (f)
         3'd0, 3'd1: return "R1";
         3'd2: return "R2";
         3'd3: return "R3";
         3'd4: return "R4";
         default: return en ? ((f == 3'd5) ? "R6" : "R7") : "R8";
      endcase
   endfunction

   // Called on a falling edge: check what is due now, drive the next cycle.
   task automatic step(input bit v, input logic [2:0] f, input logic [31:0] p, input logic [7:0] ctrl,
                       input bit we, input logic [7:0] wi, input logic [23:0] wd, input string tag_ovr);
      chk(out_valid == exp_v, "R9", {31'd0, out_valid}, {31'd0, exp_v});
      chk(out_argb == exp_argb, exp_tag, out_argb, exp_argb);
      if (exp_v && (exp_fmt == 3'd1 || exp_fmt == 3'd2 || exp_fmt == 3'd5))
         chk(out_argb[31:24] == 8'hFF, "R5", {24'd0, out_argb[31:24]}, 32'hFF);
      in_valid = v; in_fmt = f; in_pix = p; layer_ctrl = ctrl;
      tbl_we = we; tbl_idx = wi; tbl_rgb = wd;
      exp_v = v;
      if (v) begin
         exp_argb = model(f, p, ctrl[4]);
         exp_fmt  = f;
         exp_tag  = (tag_ovr != "") ? tag_ovr : tag_of(f, ctrl[4]);
      end else begin
         exp_tag = "R10";
      end
      if (we) mdl[wi] = wd;
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(20 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R10", {31'd0, out_valid}, 32'd0);
      chk(out_argb == 32'd0, "R10", out_argb, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // Fill the table.
      for (int i = 0; i < 256; i++)
         step(0, 3'd0, '0, 8'h10, 1, i[7:0], $urandom() & 24'hFFFFFF, "");

      // Directed corners.
      step(1, 3'd0, 32'h12345678, 8'h00, 0, 0, 0, "");
      step(1, 3'd1, 32'hABCDEF01, 8'h00, 0, 0, 0, "");          // R1 top byte ignored
      step(1, 3'd2, 32'hFFFF_F81F, 8'h00, 0, 0, 0, "");         // R2
      step(1, 3'd2, 32'h0000_07E0, 8'h00, 0, 0, 0, "");         // R2
      step(1, 3'd3, 32'h1234_8000, 8'h00, 0, 0, 0, "");         // R3 alpha set
      step(1, 3'd3, 32'h0000_7FFF, 8'h00, 0, 0, 0, "");         // R3 alpha clear
      step(1, 3'd4, 32'h0000_A5C3, 8'h00, 0, 0, 0, "");         // R4
      step(1, 3'd5, 32'h0000_0000, 8'h10, 0, 0, 0, "");         // R6 idx 0
      step(1, 3'd5, 32'hFFFF_FFFF, 8'h10, 0, 0, 0, "");         // R6 idx 255
      step(1, 3'd6, 32'h0000_3FAF, 8'h10, 0, 0, 0, "");         // R7 AL44
      step(1, 3'd7, 32'h0000_5AC4, 8'h10, 0, 0, 0, "");         // R7 AL88
      step(1, 3'd5, 32'h0000_0081, 8'hEF, 0, 0, 0, "");         // R8 other bits set
      step(1, 3'd6, 32'h0000_00C9, 8'h00, 0, 0, 0, "");         // R8 AL44 grey
      step(1, 3'd7, 32'h0000_7E42, 8'h00, 0, 0, 0, "");         // R8 AL88 grey
      step(1, 3'd5, 32'h0000_0033, 8'h10, 1, 8'h33, 24'h0F1E2D, "R11"); // same-cycle: old entry
      step(1, 3'd5, 32'h0000_0033, 8'h10, 0, 0, 0, "R11");               // new entry
      step(1, 3'd7, 32'h0000_9911, 8'h10, 0, 0, 0, "");
      step(0, 3'd0, '0, 8'h10, 1, 8'h11, 24'hDEADBE, "");       // R10 hold across write
      step(0, 3'd0, '0, 8'h00, 1, 8'h11, 24'h123456, "");
      step(0, 3'd3, 32'hFFFF_FFFF, 8'hFF, 0, 0, 0, "");

      // Random traffic.
      for (int n = 0; n < 4000; n++) begin
         bit v  = ($urandom() % 4) != 0;
         bit we = ($urandom() % 4) == 0;
         step(v, 3'($urandom()), $urandom(), 8'($urandom()), we, 8'($urandom()),
              24'($urandom()), "");
      end
      step(0, 3'd0, '0, 8'h00, 0, 0, 0, "");
      step(0, 3'd0, '0, 8'h00, 0, 0, 0, "");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule